// File: doc/BRIEF.md
# Multiplexed Three-Port Latching Bus Exchanger

This block connects one narrow data port, A, to two B banks of the same width, called 1B and 2B. In the B-to-A direction, each bank has its own level-sensitive storage latch. A select input decides which of the two latched values appears on port A. In the A-to-B direction, port A is written into two separate latches, one for each bank. Each bank then presents its own latched copy and has its own output enable. This lets one bus be interleaved with two paths, for example for address/data multiplexing or for interleaving two memory banks.

Every latch passes its input through while its enable is high. It holds the last value when the enable falls, and keeps holding it until the enable rises again. Each bidirectional port appears as an input vector, an output vector and a single output-enable bit, in place of a tri-state pin. The block has no clock and no reset. A latch holds an undefined value until its enable has been high once.

Top module: `xch_bus_exchanger`

## Requirements
- R1: With `sel_1b`=1 and `le_b1_to_a`=1, `a_out` equals `b1_in` and follows its changes.
- R2: When `le_b1_to_a` falls, the 1B-path latch keeps the value `b1_in` had just before the fall, and later changes of `b1_in` do not reach `a_out` while the enable stays low.
- R3: With `sel_1b`=0, `a_out` shows the 2B-path latch. That latch is transparent to `b2_in` while `le_b2_to_a`=1 and holds while it is 0.
- R4: With both B-to-A enables low, toggling `sel_1b` switches `a_out` between the two held values. Switching the select alters neither latch.
- R5: `b1_out` follows `a_in` while `le_a_to_b1`=1, and holds the last value while it is 0.
- R6: `b2_out` follows `a_in` while `le_a_to_b2`=1, and holds while it is 0. It does so independently of the 1B bank latch.
- R7: `a_oe` is 1 exactly when `oe_a_n` is 0. When `oe_a_n` is 1, the port is released and acts as an input.
- R8: `b1_oe` is the inverse of `oe_b1_n` and `b2_oe` is the inverse of `oe_b2_n`. The two are independent: both, one or neither bank may drive.
- R9: Each of the four latches holds its content across any activity on the other latches' enables, the select and the output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | W | Data arriving on port A |
| a_out | output | W | Selected B-to-A latch content |
| a_oe | output | 1 | Port A drive enable, active high |
| b1_in | input | W | Data arriving on bank 1B |
| b1_out | output | W | A-to-1B latch content |
| b1_oe | output | 1 | Bank 1B drive enable, active high |
| b2_in | input | W | Data arriving on bank 2B |
| b2_out | output | W | A-to-2B latch content |
| b2_oe | output | 1 | Bank 2B drive enable, active high |
| sel_1b | input | 1 | 1 routes the 1B path to A, 0 routes the 2B path |
| le_b1_to_a | input | 1 | Enable of the 1B-to-A latch, transparent when 1 |
| le_b2_to_a | input | 1 | Enable of the 2B-to-A latch, transparent when 1 |
| le_a_to_b1 | input | 1 | Enable of the A-to-1B latch, transparent when 1 |
| le_a_to_b2 | input | 1 | Enable of the A-to-2B latch, transparent when 1 |
| oe_a_n | input | 1 | Port A output enable, active low |
| oe_b1_n | input | 1 | Bank 1B output enable, active low |
| oe_b2_n | input | 1 | Bank 2B output enable, active low |

## Verification
The bench builds the block with its default width of 12. At that width, data patterns with opposite halves and all-ones or all-zeros words reach every bit lane, so a stuck or swapped lane is visible. Directed steps open and close each latch and switch the select while the latches hold. A long pseudo-random run then mixes enable, select and data changes, so that each latch is seen holding through the other three latches' activity. In that run an enable never falls in the same step as a data change.

// File: rtl/xch_pkg.sv
package xch_pkg;

    localparam int XCH_WIDTH = 12;
    localparam int XCH_BANKS = 2;

    typedef enum logic {
        SRC_BANK2 = 1'b0,
        SRC_BANK1 = 1'b1
    } xch_src_e;

    typedef struct packed {
        logic b1_to_a;
        logic b2_to_a;
        logic a_to_b1;
        logic a_to_b2;
    } xch_le_t;

    typedef struct packed {
        logic a_n;
        logic b1_n;
        logic b2_n;
    } xch_oe_n_t;

    function automatic logic drive_from_n(input logic en_n);
        return ~en_n;
    endfunction

endpackage

// File: rtl/xch_latch.sv
module xch_latch #(
    parameter int W = 12
) (
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_latch begin
        if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/xch_sel_mux.sv
module xch_sel_mux
    import xch_pkg::*;
#(
    parameter int W = 12
) (
    input  xch_src_e     src,
    input  logic [W-1:0] from_b1,
    input  logic [W-1:0] from_b2,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (src)
            SRC_BANK1: y = from_b1;
            default:   y = from_b2;
        endcase
    end

endmodule

// File: rtl/xch_bus_exchanger.sv
module xch_bus_exchanger
    import xch_pkg::*;
#(
    parameter int W = XCH_WIDTH
) (
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b1_in,
    output logic [W-1:0] b1_out,
    output logic         b1_oe,
    input  logic [W-1:0] b2_in,
    output logic [W-1:0] b2_out,
    output logic         b2_oe,
    input  logic         sel_1b,
    input  logic         le_b1_to_a,
    input  logic         le_b2_to_a,
    input  logic         le_a_to_b1,
    input  logic         le_a_to_b2,
    input  logic         oe_a_n,
    input  logic         oe_b1_n,
    input  logic         oe_b2_n
);

    localparam int NB = XCH_BANKS;

    xch_le_t   le;
    xch_oe_n_t oe_n;
    xch_src_e  src;

    logic [W-1:0] b_side_in  [NB];
    logic         b_side_le  [NB];
    logic [W-1:0] to_a_held  [NB];
    logic         a_side_le  [NB];
    logic [W-1:0] to_b_held  [NB];

    assign le   = '{b1_to_a: le_b1_to_a, b2_to_a: le_b2_to_a,
                    a_to_b1: le_a_to_b1, a_to_b2: le_a_to_b2};
    assign oe_n = '{a_n: oe_a_n, b1_n: oe_b1_n, b2_n: oe_b2_n};
    assign src  = sel_1b ? SRC_BANK1 : SRC_BANK2;

    assign b_side_in[0] = b1_in;
    assign b_side_in[1] = b2_in;
    assign b_side_le[0] = le.b1_to_a;
    assign b_side_le[1] = le.b2_to_a;
    assign a_side_le[0] = le.a_to_b1;
    assign a_side_le[1] = le.a_to_b2;

    // One storage latch per bank in each direction
    for (genvar g = 0; g < NB; g++) begin : g_bank
        xch_latch #(.W(W)) u_to_a (
            .en (b_side_le[g]),
            .d  (b_side_in[g]),
            .q  (to_a_held[g])
        );
        xch_latch #(.W(W)) u_to_b (
            .en (a_side_le[g]),
            .d  (a_in),
            .q  (to_b_held[g])
        );
    end

    xch_sel_mux #(.W(W)) u_mux (
        .src     (src),
        .from_b1 (to_a_held[0]),
        .from_b2 (to_a_held[1]),
        .y       (a_out)
    );

    assign b1_out = to_b_held[0];
    assign b2_out = to_b_held[1];

    assign a_oe  = drive_from_n(oe_n.a_n);
    assign b1_oe = drive_from_n(oe_n.b1_n);
    assign b2_oe = drive_from_n(oe_n.b2_n);

    // Port-level checks across latch and mux
    always_comb begin
        if (sel_1b && le_b1_to_a) begin
            // R1
            a_from_b1_transparent_chk: assert (a_out == b1_in)
                else $error("1B path not transparent to port A");
        end
        if (!sel_1b && le_b2_to_a) begin
            // R3
            a_from_b2_transparent_chk: assert (a_out == b2_in)
                else $error("2B path not transparent to port A");
        end
        if (le_a_to_b1) begin
            // R5
            b1_from_a_transparent_chk: assert (b1_out == a_in)
                else $error("A to 1B latch not transparent");
        end
        if (le_a_to_b2) begin
            // R6
            b2_from_a_transparent_chk: assert (b2_out == a_in)
                else $error("A to 2B latch not transparent");
        end
    end

endmodule

// File: tb/xch_bus_exchanger_tb.sv
module xch_bus_exchanger_tb;

    localparam int W = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0] a_in, b1_in, b2_in;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic a_oe, b1_oe, b2_oe;
    logic sel_1b, le_b1_to_a, le_b2_to_a, le_a_to_b1, le_a_to_b2;
    logic oe_a_n, oe_b1_n, oe_b2_n;

    xch_bus_exchanger #(.W(W)) u_dut (
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
        .sel_1b(sel_1b), .le_b1_to_a(le_b1_to_a), .le_b2_to_a(le_b2_to_a),
        .le_a_to_b1(le_a_to_b1), .le_a_to_b2(le_a_to_b2),
        .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n)
    );

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic [31:0] rng = 32'h1ACE_B00C;

    // reference storage
    int m_b1a, m_b2a, m_ab1, m_ab2;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // apply inputs at a falling clock edge, update model, compare mid-phase
    task automatic step(input string tag,
                        input int ai, input int b1, input int b2,
                        input bit s, input bit l1a, input bit l2a,
                        input bit la1, input bit la2,
                        input bit oa, input bit o1, input bit o2);
        @(negedge clk);
        a_in = W'(ai); b1_in = W'(b1); b2_in = W'(b2);
        sel_1b = s; le_b1_to_a = l1a; le_b2_to_a = l2a;
        le_a_to_b1 = la1; le_a_to_b2 = la2;
        oe_a_n = oa; oe_b1_n = o1; oe_b2_n = o2;
        if (l1a) m_b1a = b1 & ((1 << W) - 1);
        if (l2a) m_b2a = b2 & ((1 << W) - 1);
        if (la1) m_ab1 = ai & ((1 << W) - 1);
        if (la2) m_ab2 = ai & ((1 << W) - 1);
        #5;
        chk(tag, "a_out", int'(a_out), s ? m_b1a : m_b2a);
        chk(tag, "b1_out", int'(b1_out), m_ab1);
        chk(tag, "b2_out", int'(b2_out), m_ab2);
        chk(tag, "a_oe", int'(a_oe), int'(!oa));
        chk(tag, "b1_oe", int'(b1_oe), int'(!o1));
        chk(tag, "b2_oe", int'(b2_oe), int'(!o2));
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // open all latches (initial load)
        step("R1", 'h0A5, 'h5A0, 'h3C3, 1, 1, 1, 1, 1, 0, 0, 0);
        step("R1", 'h0A5, 'hFFF, 'h3C3, 1, 1, 1, 1, 1, 0, 0, 0);
        step("R1", 'h0A5, 'h000, 'h3C3, 1, 1, 1, 1, 1, 0, 0, 0);
        // R2: close 1B path, then change data
        step("R2", 'h0A5, 'h6B1, 'h3C3, 1, 1, 1, 1, 1, 0, 0, 0);
        step("R2", 'h0A5, 'h6B1, 'h3C3, 1, 0, 1, 1, 1, 0, 0, 0);
        step("R2", 'h0A5, 'h123, 'h3C3, 1, 0, 1, 1, 1, 0, 0, 0);
        // R3: 2B path transparency then hold
        step("R3", 'h0A5, 'h123, 'hF0F, 0, 0, 1, 1, 1, 0, 0, 0);
        step("R3", 'h0A5, 'h123, 'h0F0, 0, 0, 1, 1, 1, 0, 0, 0);
        step("R3", 'h0A5, 'h123, 'h0F0, 0, 0, 0, 1, 1, 0, 0, 0);
        step("R3", 'h0A5, 'h123, 'hAAA, 0, 0, 0, 1, 1, 0, 0, 0);
        // R4: select toggles while both held
        step("R4", 'h0A5, 'h555, 'hAAA, 1, 0, 0, 1, 1, 0, 0, 0);
        step("R4", 'h0A5, 'h555, 'hAAA, 0, 0, 0, 1, 1, 0, 0, 0);
        step("R4", 'h0A5, 'h555, 'hAAA, 1, 0, 0, 1, 1, 0, 0, 0);
        // R5: A to 1B
        step("R5", 'h7E1, 'h555, 'hAAA, 1, 0, 0, 1, 1, 0, 0, 0);
        step("R5", 'h7E1, 'h555, 'hAAA, 1, 0, 0, 0, 1, 0, 0, 0);
        step("R5", 'h18E, 'h555, 'hAAA, 1, 0, 0, 0, 1, 0, 0, 0);
        // R6: A to 2B independent
        step("R6", 'h18E, 'h555, 'hAAA, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 'hC33, 'h555, 'hAAA, 1, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 'hC33, 'h555, 'hAAA, 1, 0, 0, 1, 0, 0, 0, 0);
        // R7 / R8: output enables in all combinations
        step("R7", 'hC33, 'h555, 'hAAA, 1, 0, 0, 1, 0, 1, 0, 0);
        step("R8", 'hC33, 'h555, 'hAAA, 1, 0, 0, 1, 0, 1, 1, 0);
        step("R8", 'hC33, 'h555, 'hAAA, 1, 0, 0, 1, 0, 0, 0, 1);
        step("R8", 'hC33, 'h555, 'hAAA, 1, 0, 0, 1, 0, 0, 1, 1);
        // R9: mixed pseudo-random activity; enables never fall with data change
        begin
            bit s = 1, l1a = 0, l2a = 0, la1 = 1, la2 = 0, oa = 0, o1 = 1, o2 = 1;
            int ai = 'hC33, b1 = 'h555, b2 = 'hAAA;
            for (int i = 0; i < 400; i++) begin
                rng = nxt(rng);
                if (rng[0]) begin
                    s = rng[1]; l1a = rng[2]; l2a = rng[3]; la1 = rng[4];
                    la2 = rng[5]; oa = rng[6]; o1 = rng[7]; o2 = rng[8];
                end else begin
                    ai = int'(rng[19:8]); b1 = int'(rng[31:20]);
                    b2 = int'(rng[27:16] ^ rng[11:0]);
                end
                step("R9", ai, b1, b2, s, l1a, l2a, la1, la2, oa, o1, o2);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule